// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits at the head of a receive path and decides, while the destination address of an incoming frame is still arriving, whether the frame is kept or thrown away. The address arrives as a stream of 16-bit words, one per cycle when `word_valid` is high. The block holds the station's 48-bit address as three words. The top bit of the first word doubles as a promiscuous flag. The block also sees a flag telling it whether a receive descriptor is ready to take the frame.

Each word is judged in the cycle it arrives. A promiscuous station, or a frame whose destination carries the group bit, passes on its first word. Any other frame must match all three station words in order. The first word that differs ends the frame at once with a purge request. A frame that passes the address check is accepted only if a descriptor is available. Otherwise it is purged and a 16-bit missed-frame counter advances. The decision comes out as a one-cycle pulse on either `accept` or `purge`. A new `frame_start` clears the decision state for the next frame.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset `accept` and `purge` are 0 and `miss_count` is 0. Address words that arrive before the first `frame_start` produce no pulse.
- R2: When `host_addr[15]` (the promiscuous flag in the first station word) is 1, the first address word of a frame passes, whatever its value.
- R3: When bit 8 of the first address word (the group bit of the first transmitted octet, which sits in the upper byte) is 1, the word passes without any comparison against the station address.
- R4: Otherwise the first, second and third address words are compared with `host_addr[15:0]`, `host_addr[31:16]` and `host_addr[47:32]` in turn. The frame passes only when all three are equal.
- R5: The first address word that differs from its station word makes `purge` pulse in the next cycle. The remaining words of that frame are ignored.
- R6: A passed frame with `desc_avail` high in the cycle of its deciding word gives a one-cycle `accept` pulse in the next cycle.
- R7: A passed frame with `desc_avail` low gives a one-cycle `purge` pulse in the next cycle, and `miss_count` rises by one in that same cycle.
- R8: `accept` and `purge` are never high together, and there is at most one pulse per frame. Words after the decision are ignored until the next `frame_start`, and a `frame_start` in mid-address restarts the compare at the first word.
- R9: A `word_valid` in the same cycle as `frame_start` is taken as the first address word of the new frame.
- R10: `miss_count` wraps from 16'hFFFF to 0. `cnt_clear` zeroes it in the next cycle and takes priority over a simultaneous increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Marks the start of a new frame and clears the decision state |
| word_valid | input | 1 | `word_data` holds an address word this cycle |
| word_data | input | 16 | Destination address word |
| host_addr | input | 48 | Station address: bits [15:0] are the first word, and bit 15 is the promiscuous flag |
| desc_avail | input | 1 | A receive descriptor is free |
| cnt_clear | input | 1 | Synchronous clear of the missed-frame counter |
| accept | output | 1 | One-cycle pulse: the frame is taken |
| purge | output | 1 | One-cycle pulse: the frame is to be discarded |
| miss_count | output | 16 | Frames that passed the address check but found no descriptor |

## Verification
Unicast frames are driven with a mismatch placed at the first, second and third word. This shows that the purge is timed to the word that failed and that later words are dropped. Full matches are driven with and without a descriptor, which separates accept from a counted purge. Group-bit and promiscuous frames with otherwise foreign addresses show that the compare is bypassed only on those conditions. Restarts in mid-address, a start coinciding with the first word, stray words before any start, and a long run of back-to-back counted frames cover the reset of the word position and the counter's wrap and clear priority.

// File: rtl/afilt_pkg.sv
package afilt_pkg;

    // Outcome of judging one address word
    typedef enum logic [1:0] {
        V_WAIT = 2'd0,   // word matched, more words needed
        V_PASS = 2'd1,   // address accepted
        V_FAIL = 2'd2    // mismatch, purge
    } verdict_e;

endpackage

// File: rtl/afilt_word_cmp.sv
module afilt_word_cmp
    import afilt_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int NWORDS  = 3,
    parameter int GRP_BIT = 8,
    localparam int IDX_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
    input  logic [WORD_W-1:0]        word,
    input  logic [IDX_W-1:0]         idx,
    input  logic [NWORDS*WORD_W-1:0] host_addr,
    output verdict_e                 verdict
);
    localparam int SLOTS = 1 << IDX_W;

    logic [SLOTS-1:0] eq;
    logic             bypass;
    logic             last;

    // One comparator per station word; unused slots never match
    for (genvar i = 0; i < SLOTS; i++) begin : g_eq
        if (i < NWORDS) begin : g_real
            assign eq[i] = (word == host_addr[i*WORD_W +: WORD_W]);
        end else begin : g_pad
            assign eq[i] = 1'b0;
        end
    end

    assign bypass = (idx == '0) && (host_addr[WORD_W-1] || word[GRP_BIT]);
    assign last   = (idx == IDX_W'(NWORDS-1));

    always_comb begin
        if (bypass)        verdict = V_PASS;
        else if (!eq[idx]) verdict = V_FAIL;
        else if (last)     verdict = V_PASS;
        else               verdict = V_WAIT;
    end

endmodule

// File: rtl/afilt_miss_cnt.sv
module afilt_miss_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)      cnt_d = '0;
        else if (inc) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import afilt_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int NWORDS  = 3,
    parameter int GRP_BIT = 8,
    parameter int CNT_W   = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     frame_start,
    input  logic                     word_valid,
    input  logic [WORD_W-1:0]        word_data,
    input  logic [NWORDS*WORD_W-1:0] host_addr,
    input  logic                     desc_avail,
    input  logic                     cnt_clear,
    output logic                     accept,
    output logic                     purge,
    output logic [CNT_W-1:0]         miss_count
);
    localparam int IDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;

    typedef struct packed {
        logic             active;  // address still being judged
        logic [IDX_W-1:0] idx;     // position of the next word
        logic             acc;
        logic             pur;
    } st_t;

    st_t              st_d, st_q;
    logic             live;
    logic [IDX_W-1:0] cur_idx;
    verdict_e         verdict;
    logic             bump;

    assign live    = frame_start | st_q.active;
    assign cur_idx = frame_start ? '0 : st_q.idx;

    afilt_word_cmp #(
        .WORD_W (WORD_W),
        .NWORDS (NWORDS),
        .GRP_BIT(GRP_BIT)
    ) u_cmp (
        .word     (word_data),
        .idx      (cur_idx),
        .host_addr(host_addr),
        .verdict  (verdict)
    );

    always_comb begin
        st_d        = st_q;
        st_d.acc    = 1'b0;
        st_d.pur    = 1'b0;
        st_d.active = live;
        st_d.idx    = cur_idx;
        bump        = 1'b0;
        if (word_valid && live) begin
            unique case (verdict)
                V_WAIT: begin
                    st_d.idx = cur_idx + 1'b1;
                end
                V_FAIL: begin
                    st_d.active = 1'b0;
                    st_d.pur    = 1'b1;
                end
                V_PASS: begin
                    st_d.active = 1'b0;
                    if (desc_avail) begin
                        st_d.acc = 1'b1;
                    end else begin
                        st_d.pur = 1'b1;
                        bump     = 1'b1;
                    end
                end
                default: st_d.active = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    afilt_miss_cnt #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (bump),
        .clr  (cnt_clear),
        .count(miss_count)
    );

    assign accept = st_q.acc;
    assign purge  = st_q.pur;

endmodule

// File: rtl/afilt_chk.sv
module afilt_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             word_valid,
    input logic             desc_avail,
    input logic             cnt_clear,
    input logic             accept,
    input logic             purge,
    input logic [CNT_W-1:0] miss_count
);
    // R8
    excl_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({accept, purge}));

    // R6
    accept_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> ($past(word_valid) && $past(desc_avail)));

    // R5
    purge_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        purge |-> $past(word_valid));

    // R7
    cnt_with_purge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cnt_clear) && (miss_count != $past(miss_count))) |-> purge);

    // R10
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cnt_clear) && (miss_count != $past(miss_count)))
            |-> (miss_count == $past(miss_count) + 1'b1));

    // R10
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clear |=> (miss_count == '0));

endmodule

bind rx_addr_filter afilt_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .word_valid(word_valid),
    .desc_avail(desc_avail),
    .cnt_clear (cnt_clear),
    .accept    (accept),
    .purge     (purge),
    .miss_count(miss_count)
);

// File: tb/sim_rx_addr_filter.sv
`timescale 1ns/1ps
module sim_rx_addr_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic        word_valid = 1'b0;
    logic [15:0] word_data = 16'h0;
    logic [47:0] host_addr;
    logic        desc_avail = 1'b1;
    logic        cnt_clear = 1'b0;
    logic        accept, purge;
    logic [15:0] miss_count;

    int n_vec = 0;
    int n_bad = 0;

    localparam logic [15:0] H0 = 16'h0A1B;
    localparam logic [15:0] H1 = 16'h2C3D;
    localparam logic [15:0] H2 = 16'h4E5F;

    always #2.5 clk = ~clk;

    rx_addr_filter u0 (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .word_valid(word_valid), .word_data(word_data),
        .host_addr(host_addr), .desc_avail(desc_avail),
        .cnt_clear(cnt_clear), .accept(accept), .purge(purge),
        .miss_count(miss_count)
    );

    // Behavioural reference: expected outputs after each clock
    int m_open, m_pos, m_cnt;
    bit e_acc, e_pur;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_open = 0; m_pos = 0; m_cnt = 0; e_acc = 0; e_pur = 0;
        end else begin
            bit ok, bad, miss;
            int pos;
            logic [15:0] want;
            ok = 0; bad = 0; miss = 0;
            e_acc = 0; e_pur = 0;
            if (frame_start) begin m_open = 1; m_pos = 0; end
            pos = m_pos;
            if (word_valid && m_open == 1) begin
                want = (pos == 0) ? host_addr[15:0] :
                       (pos == 1) ? host_addr[31:16] : host_addr[47:32];
                if (pos == 0 && (host_addr[15] || word_data[8])) ok = 1;
                else if (word_data != want) bad = 1;
                else if (pos == 2) ok = 1;
                else m_pos = pos + 1;
                if (ok || bad) m_open = 0;
                if (bad) e_pur = 1;
                if (ok) begin
                    if (desc_avail) e_acc = 1;
                    else begin e_pur = 1; miss = 1; end
                end
            end
            if (cnt_clear) m_cnt = 0;
            else if (miss) m_cnt = (m_cnt + 1) % 65536;
        end
    end

    task automatic check(input string tag, input int got, input int exp);
        n_vec++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // Drive one cycle of inputs, then compare all outputs with the model
    task automatic step(input logic fs, input logic wv, input logic [15:0] wd);
        frame_start = fs; word_valid = wv; word_data = wd;
        @(negedge clk);
        check("R6 accept vs model", int'(accept), int'(e_acc));
        check("R5 purge vs model", int'(purge), int'(e_pur));
        check("R7 count vs model", int'(miss_count), m_cnt);
        frame_start = 0; word_valid = 0;
    endtask

    bit done = 0;
    initial begin
        #750000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        host_addr = {H2, H1, H0};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state and stray words before any frame start
        check("R1 accept at reset", int'(accept), 0);
        check("R1 count at reset", int'(miss_count), 0);
        step(0, 1, H0); step(0, 1, H1); step(0, 1, H2);
        check("R1 stray words", int'(accept | purge), 0);

        // R4 R6 R9 full match, start together with the first word
        step(1, 1, H0); step(0, 1, H1);
        check("R4 no pulse mid-address", int'(accept | purge), 0);
        step(0, 1, H2);
        check("R6 accept on match", int'(accept), 1);
        step(0, 1, H0);
        check("R8 word after decision", int'(accept | purge), 0);

        // R5 mismatch at second word, third word ignored
        step(1, 0, 0); step(0, 1, H0); step(0, 1, 16'h2C3C);
        check("R5 purge on word 2", int'(purge), 1);
        step(0, 1, H2);
        check("R5 later words ignored", int'(accept | purge), 0);

        // R5 mismatch at first and third words
        step(1, 1, 16'h0A1A);
        check("R5 purge on word 1", int'(purge), 1);
        step(1, 1, H0); step(0, 1, H1); step(0, 1, 16'hFFFF);
        check("R5 purge on word 3", int'(purge), 1);

        // R3 group bit bypasses the compare
        step(1, 1, 16'h0300);
        check("R3 group accepted", int'(accept), 1);

        // R2 promiscuous flag
        host_addr = {H2, H1, H0 | 16'h8000};
        step(1, 1, 16'h1234);
        check("R2 promiscuous accept", int'(accept), 1);
        host_addr = {H2, H1, H0};

        // R7 passed but no descriptor
        desc_avail = 0;
        step(1, 1, H0); step(0, 1, H1); step(0, 1, H2);
        check("R7 purge no descriptor", int'(purge), 1);
        check("R7 counted", int'(miss_count), 1);
        // R7 mismatch with no descriptor is not counted
        step(1, 1, 16'h0000);
        check("R7 mismatch not counted", int'(miss_count), 1);
        desc_avail = 1;

        // R8 restart in mid-address
        step(1, 1, H0); step(0, 1, H1); step(1, 1, H0);
        check("R8 restart no pulse", int'(accept | purge), 0);
        step(0, 1, H1); step(0, 1, H2);
        check("R8 restart accept", int'(accept), 1);

        // R10 clear wins over increment
        desc_avail = 0; cnt_clear = 1;
        step(1, 1, 16'h0100);
        cnt_clear = 0;
        check("R10 clear priority", int'(miss_count), 0);

        // R10 wrap: one counted frame per cycle
        for (int i = 0; i < 65535; i++) step(1, 1, 16'h0100);
        check("R10 count full", int'(miss_count), 16'hFFFF);
        step(1, 1, 16'h0100);
        check("R10 wrap to zero", int'(miss_count), 0);
        desc_avail = 1;
        step(0, 0, 0);

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule